// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output

This block buffers words between two unrelated clock domains. A producer writes on its own clock, and a consumer reads on a second clock that may run faster or slower without limit. Each side sees only flags computed in its own domain. Occupancy crosses the boundary as Gray-coded pointers through two-stage synchronizers, so only one bit of a pointer changes at a time.

The output has two timing behaviours, chosen by a select pin that is captured while master reset is held. In standard timing the output register changes only when the consumer asks for a word. In fall-through timing the head word moves to the output register by itself, and the empty flag then means that no valid word is on the output. With fall-through timing, the output of one instance can drive the input of a second instance directly. The full flag of the second instance drives the read enable of the first, and the empty flag of the first drives the write enable of the second. The pair then behaves as one deeper buffer. An output enable forces the data output to zero when it is low.

Top module: `dcfifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge when `wr_en_n` is low and `full_flag` is low. Words leave in the order they were stored.
- R2: In standard timing (`mode_fwft` = 0 during reset), the output register loads the head word only on a rising `rd_clk` edge with `rd_en_n` low and `rd_empty` low. Otherwise it holds its value, even after new words arrive.
- R3: In fall-through timing (`mode_fwft` = 1 during reset), a word written into an empty FIFO reaches `rd_data` without any read request. `rd_empty` falls on the third rising `rd_clk` edge after the writing edge and not before it.
- R4: In fall-through timing, a word on the output is replaced by the next word only on a rising `rd_clk` edge with `rd_en_n` low. With `rd_en_n` high it stays in place.
- R5: `mode_fwft` is sampled only while `mrst` is high. Changing it after reset has no effect until the next reset.
- R6: When `out_en` is low, `rd_data` is all zeros. When `out_en` is high, `rd_data` shows the output register.
- R7: `full_flag` rises once DEPTH words are stored. Writes attempted while it is high store nothing and overwrite nothing.
- R8: Reads attempted while `rd_empty` is high do not change `rd_data` and do not advance the read pointer.
- R9: `mrst` is synchronous and active high in both clock domains. After it is released, `rd_empty` is 1, `full_flag` is 0 and the output register is zero.
- R10: Two fall-through instances linked as described above, sharing one clock between them, pass every word through in order.
- R11: Order and content are kept for continuous traffic when the two clocks have unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst | input | 1 | Master reset, active high, synchronous to each clock |
| mode_fwft | input | 1 | Timing select captured during reset: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| out_en | input | 1 | Output enable, active high; low forces `rd_data` to zero |
| rd_data | output | WIDTH | Output register, gated by `out_en` |
| rd_empty | output | 1 | Standard: no stored word. Fall-through: output not valid |
| full_flag | output | 1 | DEPTH words stored (write domain) |

## Verification
The bench attacks the exact fall-through latency. It checks that the flag is still set after two read edges and cleared after the third. A design that skipped a synchronizer stage or needed a read request would fail here. It fills the buffer and then keeps write enable low. A full comparison that was off by one bit would wrap the pointer and overwrite the oldest word, and draining would then return wrong data or an extra word. It drives read enable into an empty buffer in both timings, where a missing empty guard would move the read pointer past the write pointer. It also changes the select pin after reset and links two instances as a chain, which catches a mode that is not latched and an empty-to-write-enable polarity that would duplicate or drop words.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef enum logic {
        TIMING_STD  = 1'b0,
        TIMING_FWFT = 1'b1
    } timing_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
    parameter int W  = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_n,
    input  logic [AW:0]   rsync_gray,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wr_gray,
    output logic          full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [AW:0] wbin;
    logic [AW:0] wbin_nxt;

    assign wbin_nxt = wbin + PW'(1);
    assign full     = (wr_gray == {~rsync_gray[AW:AW-1], rsync_gray[AW-2:0]});
    assign we       = !wr_en_n && !full;
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin    <= '0;
            wr_gray <= '0;
        end else if (we) begin
            wbin    <= wbin_nxt;
            wr_gray <= PW'(bin2gray(32'(wbin_nxt)));
        end
    end

    logic [AW:0] rbin_seen;
    assign rbin_seen = PW'(gray2bin(32'(rsync_gray)));

    // R7
    occupancy_chk: assert property (@(posedge clk) disable iff (rst)
        PW'(wbin - rbin_seen) <= PW'(DEPTH));

    // R9
    reset_full_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !full);

endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int W  = 18,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_in,
    input  logic          rd_en_n,
    input  logic [AW:0]   wsync_gray,
    input  logic [W-1:0]  mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rd_gray,
    output logic [W-1:0]  dout,
    output logic          empty_o
);
    localparam int PW = AW + 1;

    timing_e     mode_q;
    logic [AW:0] rbin;
    logic [AW:0] rbin_nxt;
    logic        ov;
    logic        fifo_empty;
    logic        take;

    assign fifo_empty = (rd_gray == wsync_gray);
    assign rbin_nxt   = rbin + PW'(1);
    assign raddr      = rbin[AW-1:0];

    always_comb begin
        case (mode_q)
            TIMING_FWFT: take = (!ov || !rd_en_n) && !fifo_empty;
            default:     take = !rd_en_n && !fifo_empty;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= timing_e'(mode_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rd_gray <= '0;
            dout    <= '0;
            ov      <= 1'b0;
        end else if (take) begin
            rbin    <= rbin_nxt;
            rd_gray <= PW'(bin2gray(32'(rbin_nxt)));
            dout    <= mem_q;
            ov      <= 1'b1;
        end else if (!rd_en_n) begin
            ov      <= 1'b0;
        end
    end

    assign empty_o = (mode_q == TIMING_FWFT) ? !ov : fifo_empty;

    // R2
    std_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TIMING_STD && rd_en_n) |=> $stable(dout));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> ($stable(dout) && $stable(rd_gray)));

    // R4
    fwft_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TIMING_FWFT && !empty_o && rd_en_n) |=> ($stable(dout) && !empty_o));

    // R5
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

    // R9
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (empty_o && dout == '0));

endmodule

// File: rtl/dcfifo.sv
module dcfifo
    import dcfifo_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             mrst,
    input  logic             mode_fwft,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en_n,
    input  logic             out_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_empty,
    output logic             full_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic             we;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    logic [PW-1:0]    wr_gray;
    logic [PW-1:0]    rd_gray;
    logic [PW-1:0]    wr_gray_s;
    logic [PW-1:0]    rd_gray_s;
    logic [WIDTH-1:0] mem_q;
    logic [WIDTH-1:0] dout;

    dcfifo_mem #(.W(WIDTH), .AW(AW)) mem_i (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    dcfifo_sync #(.W(PW), .STAGES(2)) r2w_i (
        .clk (wr_clk),
        .rst (mrst),
        .d   (rd_gray),
        .q   (rd_gray_s)
    );

    dcfifo_sync #(.W(PW), .STAGES(2)) w2r_i (
        .clk (rd_clk),
        .rst (mrst),
        .d   (wr_gray),
        .q   (wr_gray_s)
    );

    dcfifo_wr_ctl #(.AW(AW)) wctl_i (
        .clk        (wr_clk),
        .rst        (mrst),
        .wr_en_n    (wr_en_n),
        .rsync_gray (rd_gray_s),
        .we         (we),
        .waddr      (waddr),
        .wr_gray    (wr_gray),
        .full       (full_flag)
    );

    dcfifo_rd_ctl #(.W(WIDTH), .AW(AW)) rctl_i (
        .clk        (rd_clk),
        .rst        (mrst),
        .mode_in    (mode_fwft),
        .rd_en_n    (rd_en_n),
        .wsync_gray (wr_gray_s),
        .mem_q      (mem_q),
        .raddr      (raddr),
        .rd_gray    (rd_gray),
        .dout       (dout),
        .empty_o    (rd_empty)
    );

    assign rd_data = out_en ? dout : '0;

endmodule

// File: tb/dcfifo_tb_top.sv
module dcfifo_tb_top;
    localparam int W = 18;
    localparam int D = 16;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mrst = 1'b1;
    logic          mode_fwft = 1'b0;
    logic          wr_en_n = 1'b1;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          out_en = 1'b1;
    logic [W-1:0]  rd_data;
    logic          rd_empty;
    logic          full_flag;

    // chained pair
    logic          c_wr_en_n = 1'b1;
    logic [W-1:0]  c_wr_data = '0;
    logic          c_rd_en_n = 1'b1;
    logic [W-1:0]  c_out;
    logic          c_empty;
    logic          a_full;
    logic [W-1:0]  link_data;
    logic          link_empty;
    logic          b_full;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] cexp_q[$];

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.5 rd_clk = ~rd_clk;

    dcfifo #(.WIDTH(W), .DEPTH(D)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .mode_fwft(mode_fwft),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .out_en(out_en),
        .rd_data(rd_data), .rd_empty(rd_empty), .full_flag(full_flag)
    );

    dcfifo #(.WIDTH(W), .DEPTH(4)) cha_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .mode_fwft(1'b1),
        .wr_en_n(c_wr_en_n), .wr_data(c_wr_data), .rd_en_n(b_full), .out_en(1'b1),
        .rd_data(link_data), .rd_empty(link_empty), .full_flag(a_full)
    );

    dcfifo #(.WIDTH(W), .DEPTH(4)) chb_i (
        .wr_clk(rd_clk), .rd_clk(rd_clk), .mrst(mrst), .mode_fwft(1'b1),
        .wr_en_n(link_empty), .wr_data(link_data), .rd_en_n(c_rd_en_n), .out_en(1'b1),
        .rd_data(c_out), .rd_empty(c_empty), .full_flag(b_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge wr_clk);
        mrst = 1'b1; mode_fwft = mode; wr_en_n = 1'b1; rd_en_n = 1'b1;
        c_wr_en_n = 1'b1; c_rd_en_n = 1'b1;
        repeat (6) @(negedge wr_clk);
        mrst = 1'b0;
        exp_q.delete();
        cexp_q.delete();
    endtask

    // driver: pushes each accepted word into the scoreboard
    task automatic push(input logic [W-1:0] d);
        @(negedge wr_clk);
        while (full_flag) begin
            wr_en_n = 1'b1;
            @(negedge wr_clk);
        end
        wr_en_n = 1'b0; wr_data = d;
        exp_q.push_back(d);
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic push_burst(input int n, input int seed);
        for (int i = 0; i < n; i++) push(W'(seed * 37 + i * 11));
        wr_idle();
    endtask

    // monitor, standard timing
    task automatic drain_std(input int n, input string tag);
        int got = 0;
        logic pend = 1'b0;
        while (got < n) begin
            @(negedge rd_clk);
            if (pend) begin
                chk(tag, 32'(rd_data), 32'(exp_q.pop_front()));
                got++;
            end
            pend = !rd_empty && (got < n);
            rd_en_n = !pend;
        end
        rd_en_n = 1'b1;
    endtask

    // monitor, fall-through timing
    task automatic drain_fwft(input int n, input string tag);
        int got = 0;
        while (got < n) begin
            @(negedge rd_clk);
            if (!rd_empty) begin
                chk(tag, 32'(rd_data), 32'(exp_q.pop_front()));
                got++;
                rd_en_n = 1'b0;
            end else begin
                rd_en_n = 1'b1;
            end
        end
        @(negedge rd_clk);
        rd_en_n = 1'b1;
    endtask

    task automatic chain_push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            while (a_full) begin
                c_wr_en_n = 1'b1;
                @(negedge wr_clk);
            end
            c_wr_en_n = 1'b0; c_wr_data = W'(18'h2A000 + i * 5);
            cexp_q.push_back(c_wr_data);
        end
        @(negedge wr_clk);
        c_wr_en_n = 1'b1;
    endtask

    task automatic chain_drain(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge rd_clk);
            if (!c_empty && cexp_q.size() > 0) begin
                chk("R10 chain order", 32'(c_out), 32'(cexp_q.pop_front()));
                got++;
                c_rd_en_n = 1'b0;
            end else begin
                c_rd_en_n = 1'b1;
            end
        end
        @(negedge rd_clk);
        c_rd_en_n = 1'b1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // ---------------- standard timing ----------------
        do_reset(1'b0);
        repeat (3) @(negedge rd_clk);
        chk("R9 empty after reset", 32'(rd_empty), 32'd1);
        chk("R9 full after reset", 32'(full_flag), 32'd0);
        chk("R9 data after reset", 32'(rd_data), 32'd0);

        push(18'h1A5A5); wr_idle();
        repeat (8) @(negedge rd_clk);
        chk("R2 no read no change", 32'(rd_data), 32'd0);
        chk("R2 word available", 32'(rd_empty), 32'd0);
        drain_std(1, "R1 first word");

        // R8: reads into an empty FIFO
        @(negedge rd_clk); rd_en_n = 1'b0;
        repeat (4) @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk("R8 data held", 32'(rd_data), 32'h1A5A5);
        chk("R8 still empty", 32'(rd_empty), 32'd1);

        // R6: output enable
        @(negedge rd_clk); out_en = 1'b0; #1;
        chk("R6 gated low", 32'(rd_data), 32'd0);
        out_en = 1'b1; #1;
        chk("R6 enabled", 32'(rd_data), 32'h1A5A5);

        // R7: fill, then write while full
        push_burst(D, 3);
        repeat (2) @(negedge wr_clk);
        chk("R7 full at depth", 32'(full_flag), 32'd1);
        wr_data = 18'h3FFFF; wr_en_n = 1'b0;
        repeat (4) @(negedge wr_clk);
        wr_en_n = 1'b1;
        drain_std(D, "R7 no overwrite");
        repeat (10) @(negedge rd_clk);
        chk("R7 no extra word", 32'(rd_empty), 32'd1);
        repeat (6) @(negedge wr_clk);
        chk("R7 full cleared", 32'(full_flag), 32'd0);

        // R11: streaming, standard
        fork
            push_burst(40, 9);
            drain_std(40, "R11 stream std");
        join

        // ---------------- fall-through timing ----------------
        do_reset(1'b1);
        @(negedge wr_clk); mode_fwft = 1'b0;   // R5: ignored after reset
        repeat (3) @(negedge rd_clk);
        chk("R9 not ready after reset", 32'(rd_empty), 32'd1);

        @(negedge wr_clk); wr_en_n = 1'b0; wr_data = 18'h0BEEF;
        exp_q.push_back(18'h0BEEF);
        @(posedge wr_clk);
        fork
            begin @(negedge wr_clk); wr_en_n = 1'b1; end
        join_none
        repeat (2) @(posedge rd_clk);
        #1 chk("R3 not before third edge", 32'(rd_empty), 32'd1);
        @(posedge rd_clk);
        #1 chk("R3 ready at third edge", 32'(rd_empty), 32'd0);
        chk("R5 fall-through kept", 32'(rd_data), 32'h0BEEF);

        push(18'h12345); wr_idle();
        repeat (10) @(negedge rd_clk);
        chk("R4 head held", 32'(rd_data), 32'h0BEEF);
        drain_fwft(2, "R4 advance");
        chk("R4 empty after drain", 32'(rd_empty), 32'd1);

        @(negedge rd_clk); rd_en_n = 1'b0;
        repeat (4) @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk("R8 fwft data held", 32'(rd_data), 32'h12345);
        chk("R8 fwft still empty", 32'(rd_empty), 32'd1);

        fork
            push_burst(40, 21);
            drain_fwft(40, "R11 stream fwft");
        join

        // ---------------- chained pair ----------------
        fork
            chain_push(12);
            chain_drain(12);
        join

        summary();
        $finish;
    end

endmodule